// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a single-cycle processor and decides, once per clock, which address is fetched next. The address it holds goes straight to the instruction memory. The block also computes the address of the next word, which is the program counter plus four.

Three kinds of successor are possible:

- The next word in sequence.
- A conditional branch target. This is the next-word address plus the sign-extended 16-bit offset of the current instruction, scaled by four.
- An absolute jump target. This takes the upper bits of the next-word address, appends the 26-bit target field, and adds two zero bits at the bottom.

The decoder provides a branch strobe and a jump strobe. The ALU provides its zero flag, which decides whether an equality branch is taken. The register loads every rising edge and resets synchronously to address zero.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pcOut` becomes 0 after that edge.
- R2: With `branchEn` = 0 and `jumpEn` = 0, the next `pcOut` is the current `pcOut` + 4.
- R3: With `branchEn` = 1, `aluZero` = 1 and `jumpEn` = 0, the next `pcOut` is `pcPlus4` + (sign-extended `immField` << 2). `immField[15]` is the sign bit.
- R4: With `branchEn` = 1, `aluZero` = 0 and `jumpEn` = 0, the next `pcOut` is `pcPlus4`.
- R5: With `jumpEn` = 1, the next `pcOut` is {`pcPlus4[31:28]`, `jumpField[25:0]`, 2'b00}.
- R6: When `jumpEn` and `branchEn` are both 1, the jump target of R5 is used, whatever the value of `aluZero`.
- R7: Bits [1:0] of `pcOut` are always 0 outside reset.
- R8: `pcPlus4` always equals `pcOut` + 4, modulo 2^32.
- R9: When `branchEn` = 0, `aluZero` has no effect on the next `pcOut`.
- R10: All address arithmetic wraps modulo 2^32. A backward branch from address 0 reaches 0xFFFFFFFC, and the step after 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branchEn | input | 1 | Current instruction is a conditional branch |
| jumpEn | input | 1 | Current instruction is an absolute jump |
| aluZero | input | 1 | ALU result is zero (branch condition) |
| immField | input | 16 | Signed word offset of the current instruction |
| jumpField | input | 26 | Word target field of a jump |
| pcOut | output | 32 | Current program counter, to instruction memory |
| pcPlus4 | output | 32 | Address of the following word |

## Verification
The assertions check on every cycle:

- the relation between `pcPlus4` and `pcOut`;
- word alignment;
- the reset value;
- the successor address in each of the sequential, taken, not-taken and jump cases, against the previous cycle's inputs.

Only the bench scenarios can show the points that need a chosen history. These are wraparound across the top of the address space, the extremes of the offset range, and the fact that the zero flag is ignored when no branch is requested. The bench covers them by sweeping every strobe combination against a set of offsets and jump fields while it tracks its own model of the address.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  // Strobes from the select decoder to the address datapath.
  typedef struct packed {
    logic selJump;
    logic selBranch;
  } pcStrobesT;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic      branchEn,
  input  logic      jumpEn,
  input  logic      aluZero,
  output pcStrobesT strobes
);

  // Jump outranks branch; a branch is only taken on a zero result.
  always_comb begin
    strobes.selJump   = jumpEn;
    strobes.selBranch = branchEn & aluZero & ~jumpEn;
  end

endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input  logic                clk,
  input  logic                rst,
  input  pcStrobesT           strobes,
  input  logic [IMM_W-1:0]    immField,
  input  logic [JFIELD_W-1:0] jumpField,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   pcPlus4
);

  localparam int SHIFT   = 2;
  localparam int UPPER_W = ADDR_W - JFIELD_W - SHIFT;
  localparam int EXT_W   = ADDR_W - IMM_W - SHIFT;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] branchOff;
  logic [ADDR_W-1:0] branchAddr;
  logic [ADDR_W-1:0] jumpAddr;
  logic [ADDR_W-1:0] nextPc;

  always_comb begin
    seqAddr    = pcReg + ADDR_W'(4);
    branchOff  = {{EXT_W{immField[IMM_W-1]}}, immField, {SHIFT{1'b0}}};
    branchAddr = seqAddr + branchOff;
    jumpAddr   = {seqAddr[ADDR_W-1 -: UPPER_W], jumpField, {SHIFT{1'b0}}};
    if (strobes.selJump)        nextPc = jumpAddr;
    else if (strobes.selBranch) nextPc = branchAddr;
    else                        nextPc = seqAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= nextPc;
  end

  assign pcOut   = pcReg;
  assign pcPlus4 = seqAddr;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                branchEn,
  input  logic                jumpEn,
  input  logic                aluZero,
  input  logic [IMM_W-1:0]    immField,
  input  logic [JFIELD_W-1:0] jumpField,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   pcPlus4
);

  pcStrobesT strobes;

  pc_seq_ctrl u_ctrl (
    .branchEn (branchEn),
    .jumpEn   (jumpEn),
    .aluZero  (aluZero),
    .strobes  (strobes)
  );

  pc_seq_dp #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .JFIELD_W (JFIELD_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .immField  (immField),
    .jumpField (jumpField),
    .pcOut     (pcOut),
    .pcPlus4   (pcPlus4)
  );

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input logic                clk,
  input logic                rst,
  input logic                branchEn,
  input logic                jumpEn,
  input logic                aluZero,
  input logic [IMM_W-1:0]    immField,
  input logic [JFIELD_W-1:0] jumpField,
  input logic [ADDR_W-1:0]   pcOut,
  input logic [ADDR_W-1:0]   pcPlus4
);

  localparam int UPPER_W = ADDR_W - JFIELD_W - 2;
  localparam int EXT_W   = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] offScaled;
  assign offScaled = {{EXT_W{immField[IMM_W-1]}}, immField, 2'b00};

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> pcOut == '0);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!branchEn && !jumpEn) |=> pcOut == $past(pcPlus4));

  a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (branchEn && aluZero && !jumpEn) |=> pcOut == $past(pcPlus4 + offScaled));

  a_r4_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
    (branchEn && !aluZero && !jumpEn) |=> pcOut == $past(pcPlus4));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    jumpEn |=> pcOut == {$past(pcPlus4[ADDR_W-1 -: UPPER_W]), $past(jumpField), 2'b00});

  a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
    pcOut[1:0] == 2'b00);

  a_r8_plus4: assert property (@(posedge clk) disable iff (rst)
    pcPlus4 == pcOut + ADDR_W'(4));

endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W   (ADDR_W),
  .IMM_W    (IMM_W),
  .JFIELD_W (JFIELD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .branchEn  (branchEn),
  .jumpEn    (jumpEn),
  .aluZero   (aluZero),
  .immField  (immField),
  .jumpField (jumpField),
  .pcOut     (pcOut),
  .pcPlus4   (pcPlus4)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchEn = 1'b0;
  logic        jumpEn = 1'b0;
  logic        aluZero = 1'b0;
  logic [15:0] immField = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] pcOut;
  logic [31:0] pcPlus4;

  int checks = 0;
  int fails = 0;
  logic [31:0] expPc = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_sequencer u_dut (
    .clk       (clk),
    .rst       (rst),
    .branchEn  (branchEn),
    .jumpEn    (jumpEn),
    .aluZero   (aluZero),
    .immField  (immField),
    .jumpField (jumpField),
    .pcOut     (pcOut),
    .pcPlus4   (pcPlus4)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs, checks the next PC after the rising edge.
  task automatic step(string req, bit b, bit j, bit z, logic [15:0] imm, logic [25:0] jf);
    logic [31:0] seq, nxt;
    branchEn = b; jumpEn = j; aluZero = z; immField = imm; jumpField = jf;
    seq = expPc + 32'd4;
    if (j)          nxt = {seq[31:28], jf, 2'b00};
    else if (b && z) nxt = seq + {{14{imm[15]}}, imm, 2'b00};
    else            nxt = seq;
    #0.5;
    check("R8", pcPlus4, seq);
    @(posedge clk);
    #1;
    check(req, pcOut, nxt);
    check("R7", {30'd0, pcOut[1:0]}, 32'd0);
    expPc = nxt;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [8];
    logic [25:0] jfs [4];
    imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0123, 16'hFF00, 16'h0040};
    jfs  = '{26'h0000000, 26'h3FFFFFF, 26'h1555555, 26'h0000100};

    repeat (2) @(posedge clk);
    #1;
    check("R1", pcOut, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 sequential run, R9 zero flag toggled with no branch
    for (int k = 0; k < 6; k++) step("R2", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
    for (int k = 0; k < 4; k++) step("R9", 1'b0, 1'b0, k[0], 16'hFFFF, 26'h0);

    // R3 / R4 across offsets
    foreach (imms[i]) begin
      step("R4", 1'b1, 1'b0, 1'b0, imms[i], 26'h0);
      step("R3", 1'b1, 1'b0, 1'b1, imms[i], 26'h0);
    end

    // R5 jumps, R6 jump over branch
    foreach (jfs[i]) begin
      step("R5", 1'b0, 1'b1, 1'b0, 16'h0010, jfs[i]);
      step("R6", 1'b1, 1'b1, 1'b1, 16'h0010, jfs[i]);
      step("R6", 1'b1, 1'b1, 1'b0, 16'hFFF0, jfs[i]);
    end

    // Full strobe sweep
    for (int m = 0; m < 8; m++)
      foreach (imms[i]) step("R2", m[0], m[1], m[2], imms[i], jfs[i % 4]);

    // R10 wraparound: reset to 0, branch back by 2 words, then step past the top
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", pcOut, 32'd0);
    @(negedge clk); rst = 1'b0; expPc = 32'd0;
    step("R10", 1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0);
    check("R10", pcOut, 32'hFFFF_FFFC);
    step("R10", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
    check("R10", pcOut, 32'h0000_0000);
    // Jump from top region keeps upper nibble of PC+4
    step("R10", 1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0);
    step("R5", 1'b0, 1'b1, 1'b0, 16'h0, 26'h0000001);
    check("R10", pcOut, 32'h0000_0004);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule